// File: doc/BRIEF.md
# SDRAM Command Sequencer

This block sits between a host and a single-rank SDRAM and converts one-at-a-time host requests into command cycles on the chip-select, row-strobe, column-strobe and write-enable pins, together with the bank-select and address pins. The host offers a request (open row, column read, column write, close row, refresh, mode load) with a valid/ready handshake; the sequencer keeps track of which of the four banks have an open row and holds the request back until every row, precharge, refresh and mode-load spacing rule is met. All spacing rules are given as parameters in whole clock cycles, so a slower or faster clock only needs new parameter values.

A free-running refresh interval timer raises a refresh demand every `T_REFI` cycles. While a demand is pending the host sees `reqReady` low; the sequencer closes every open row with one all-bank precharge, waits out the precharge time and issues an auto refresh, after which host traffic resumes. Cycles in which nothing may be issued show a no-operation on the pins. Data movement, pads and low-power states are handled elsewhere.

Top module: `sdram_cmd_seq`

## Requirements
- R1: Host op codes are 0 open row, 1 read, 2 write, 3 close row, 4 refresh, 5 mode load. A granted legal request appears on the pins in the cycle after the handshake edge, with {csN,rasN,casN,weN} = 0011 open, 0101 read, 0100 write, 0010 close, 0001 refresh, 0000 mode load; bank pins and address pins carry the request's bank and address (both zero for a refresh).
- R2: Whenever no command is issued, including right after reset, the pins show a no-operation, 0111, with reqReady low while reqValid is low.
- R3: Address bit 10 selects all banks for a close-row request and requests automatic row closing for a read or write; an automatic close counts from the column command as a close of that bank.
- R4: A request that is illegal for the current bank state (open row on an open bank, read or write on an idle bank, refresh or mode load while any bank is open, op code 6 or 7) is accepted at once and dropped: the pins show a no-operation for it.
- R5: A read or write follows the open-row of its bank by at least `T_RCD` cycles; with automatic close it also waits until `T_RAS` cycles have passed since that open-row.
- R6: A close row follows its bank's open-row by at least `T_RAS` cycles and its bank's last write by at least `T_WR` cycles.
- R7: Open-rows to one bank are at least `T_RC` apart, an open-row follows that bank's close by at least `T_RP` cycles (`T_WR`+`T_RP` after a write with automatic close), and open-rows to any two banks are at least `T_RRD` apart.
- R8: No command follows a refresh by fewer than `T_RFC` cycles or a mode load by fewer than `T_MRD` cycles; refresh and mode load also wait for every bank's `T_RP`.
- R9: A refresh demand arises every `T_REFI` cycles; while it is pending the host is stalled, open rows are closed by one all-bank close, and the refresh follows, so consecutive refreshes are never more than `T_REFI` plus a fixed bound apart.
- R10: A request held valid is issued in the first cycle in which every applicable spacing rule allows it, not later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; everything updates on its rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Host request present |
| reqReady | output | 1 | Request taken at this edge |
| reqOp | input | 3 | Request op code (see R1) |
| reqBank | input | 2 | Target bank |
| reqAddr | input | ADDR_W | Row, column or mode value; bit 10 as in R3 |
| sdCsN | output | 1 | Chip select, active low |
| sdRasN | output | 1 | Row strobe, active low |
| sdCasN | output | 1 | Column strobe, active low |
| sdWeN | output | 1 | Write enable, active low |
| sdBa | output | 2 | Bank select pins |
| sdAddr | output | ADDR_W | Address pins |

## Verification
The two functions that collide are the refresh demand and host service: a refresh can come due while a host request is already waiting on a row or write-recovery timer. The bench shortens the refresh interval and keeps random open, column and close traffic flowing so that demands regularly land on held requests and on open banks. Every command seen on the pins is judged against per-bank timestamps of the spacing rules, and the distance between refreshes is held to the interval plus the worst-case drain time.

// File: rtl/sdram_seq_pkg.sv
package sdram_seq_pkg;

  localparam int BANKS  = 4;
  localparam int BANK_W = 2;

  // Host op codes
  localparam logic [2:0] OP_ACT      = 3'd0;
  localparam logic [2:0] OP_READ     = 3'd1;
  localparam logic [2:0] OP_WRITE    = 3'd2;
  localparam logic [2:0] OP_PRECH    = 3'd3;
  localparam logic [2:0] OP_REFRESH  = 3'd4;
  localparam logic [2:0] OP_LOADMODE = 3'd5;

  // Pin encodings {csN, rasN, casN, weN}
  localparam logic [3:0] PIN_NOP      = 4'b0111;
  localparam logic [3:0] PIN_ACT      = 4'b0011;
  localparam logic [3:0] PIN_READ     = 4'b0101;
  localparam logic [3:0] PIN_WRITE    = 4'b0100;
  localparam logic [3:0] PIN_PRECH    = 4'b0010;
  localparam logic [3:0] PIN_REFRESH  = 4'b0001;
  localparam logic [3:0] PIN_LOADMODE = 4'b0000;

  // Strobes from control to the timer datapath, valid in the issue cycle
  typedef struct packed {
    logic              act;
    logic              colRd;
    logic              colWr;
    logic              prech;
    logic              all;
    logic              refresh;
    logic              loadMode;
    logic              autoPre;
    logic [BANK_W-1:0] bank;
  } seqStrobe_t;

endpackage

// File: rtl/seq_bank_timers.sv
module seq_bank_timers
  import sdram_seq_pkg::*;
#(
  parameter int T_RCD  = 2,
  parameter int T_RAS  = 4,
  parameter int T_RC   = 6,
  parameter int T_RP   = 2,
  parameter int T_WR   = 2,
  parameter int T_RRD  = 2,
  parameter int T_RFC  = 7,
  parameter int T_MRD  = 2,
  parameter int T_REFI = 1560
) (
  input  logic             clk,
  input  logic             rstN,
  input  seqStrobe_t       strobe,
  output logic [BANKS-1:0] bankOpen,
  output logic [BANKS-1:0] colOk,
  output logic [BANKS-1:0] rasDone,
  output logic [BANKS-1:0] preOk,
  output logic [BANKS-1:0] rpDone,
  output logic [BANKS-1:0] rcDone,
  output logic             rrdOk,
  output logic             quietOk,
  output logic             refDue
);

  localparam int TSUM  = T_RCD + T_RAS + T_RC + T_RP + T_WR + T_RRD + T_RFC + T_MRD;
  localparam int CNT_W = $clog2(TSUM + 1);
  localparam int REF_W = $clog2(T_REFI + 1);

  logic anyCmd;
  assign anyCmd = strobe.act | strobe.colRd | strobe.colWr | strobe.prech |
                  strobe.refresh | strobe.loadMode;

  // Per-bank timers
  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    logic [CNT_W-1:0] rcdCnt, rasCnt, rcCnt, rpCnt, wrCnt;
    logic             open;
    logic             hit, colHit, preHit, closeNow;
    logic [CNT_W-1:0] rpLoad;

    assign hit      = (strobe.bank == BANK_W'(b));
    assign colHit   = (strobe.colRd | strobe.colWr) & hit;
    assign preHit   = strobe.prech & (strobe.all | hit);
    assign closeNow = open & (preHit | (colHit & strobe.autoPre));
    assign rpLoad   = (strobe.colWr & hit & strobe.autoPre) ? CNT_W'(T_WR + T_RP - 1)
                                                            : CNT_W'(T_RP - 1);

    always_ff @(posedge clk) begin
      if (!rstN) begin
        rcdCnt <= '0;
        rasCnt <= '0;
        rcCnt  <= '0;
        rpCnt  <= '0;
        wrCnt  <= '0;
        open   <= 1'b0;
      end else begin
        if (strobe.act && hit) begin
          rcdCnt <= CNT_W'(T_RCD - 1);
          rasCnt <= CNT_W'(T_RAS - 1);
          rcCnt  <= CNT_W'(T_RC - 1);
          open   <= 1'b1;
        end else begin
          if (rcdCnt != '0) rcdCnt <= rcdCnt - 1'b1;
          if (rasCnt != '0) rasCnt <= rasCnt - 1'b1;
          if (rcCnt  != '0) rcCnt  <= rcCnt - 1'b1;
          if (closeNow) open <= 1'b0;
        end
        if (closeNow)           rpCnt <= rpLoad;
        else if (rpCnt != '0)   rpCnt <= rpCnt - 1'b1;
        if (strobe.colWr && hit && !strobe.autoPre) wrCnt <= CNT_W'(T_WR - 1);
        else if (wrCnt != '0)                       wrCnt <= wrCnt - 1'b1;
      end
    end

    assign bankOpen[b] = open;
    assign colOk[b]    = (rcdCnt == '0);
    assign rasDone[b]  = (rasCnt == '0);
    assign preOk[b]    = (rasCnt == '0) && (wrCnt == '0);
    assign rpDone[b]   = (rpCnt == '0);
    assign rcDone[b]   = (rcCnt == '0);

    AST_ACT_ON_IDLE_BANK: assert property (@(posedge clk) disable iff (!rstN)
      (strobe.act && hit) |-> (!open && rpCnt == '0 && rcCnt == '0)); // R7
    AST_COL_AFTER_RCD: assert property (@(posedge clk) disable iff (!rstN)
      colHit |-> (open && rcdCnt == '0)); // R5
    AST_PRE_AFTER_RAS_WR: assert property (@(posedge clk) disable iff (!rstN)
      (preHit && open) |-> (rasCnt == '0 && wrCnt == '0)); // R6
  end

  // Global timers: bank-to-bank activate spacing and post-refresh/mode quiet time
  logic [CNT_W-1:0] rrdCnt, quietCnt;
  logic [REF_W-1:0] refCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rrdCnt   <= '0;
      quietCnt <= '0;
      refCnt   <= REF_W'(T_REFI - 1);
    end else begin
      if (strobe.act)          rrdCnt <= CNT_W'(T_RRD - 1);
      else if (rrdCnt != '0)   rrdCnt <= rrdCnt - 1'b1;
      if (strobe.refresh)       quietCnt <= CNT_W'(T_RFC - 1);
      else if (strobe.loadMode) quietCnt <= CNT_W'(T_MRD - 1);
      else if (quietCnt != '0)  quietCnt <= quietCnt - 1'b1;
      if (refCnt == '0) refCnt <= REF_W'(T_REFI - 1);
      else              refCnt <= refCnt - 1'b1;
    end
  end

  assign rrdOk   = (rrdCnt == '0);
  assign quietOk = (quietCnt == '0);
  assign refDue  = (refCnt == '0);

  AST_QUIET_AFTER_REF_MRS: assert property (@(posedge clk) disable iff (!rstN)
    anyCmd |-> (quietCnt == '0)); // R8
  AST_ACT_SPACING: assert property (@(posedge clk) disable iff (!rstN)
    strobe.act |-> (rrdCnt == '0)); // R7

endmodule

// File: rtl/seq_ctrl.sv
module seq_ctrl
  import sdram_seq_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int AP_BIT    = 10,
  parameter int REF_BOUND = 24
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [2:0]        reqOp,
  input  logic [BANK_W-1:0] reqBank,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [BANKS-1:0]  bankOpen,
  input  logic [BANKS-1:0]  colOk,
  input  logic [BANKS-1:0]  rasDone,
  input  logic [BANKS-1:0]  preOk,
  input  logic [BANKS-1:0]  rpDone,
  input  logic [BANKS-1:0]  rcDone,
  input  logic              rrdOk,
  input  logic              quietOk,
  input  logic              refDue,
  output seqStrobe_t        strobe,
  output logic [3:0]        cmdPins,
  output logic [BANK_W-1:0] pinBa,
  output logic [ADDR_W-1:0] pinAddr
);

  localparam int AGE_W = $clog2(REF_BOUND + 2);

  logic              refPending;
  logic              illegal, timingOk, hostGo, apBit;
  logic [3:0]        nextPins;
  logic [BANK_W-1:0] nextBa;
  logic [ADDR_W-1:0] nextAddr;
  logic [AGE_W-1:0]  pendAge;

  assign apBit = reqAddr[AP_BIT];

  // Legality and timing of the offered host request
  always_comb begin
    illegal  = 1'b0;
    timingOk = 1'b0;
    case (reqOp)
      OP_ACT: begin
        illegal  = bankOpen[reqBank];
        timingOk = rcDone[reqBank] && rpDone[reqBank] && rrdOk;
      end
      OP_READ, OP_WRITE: begin
        illegal  = !bankOpen[reqBank];
        timingOk = colOk[reqBank] && (!apBit || rasDone[reqBank]);
      end
      OP_PRECH: timingOk = apBit ? (&preOk) : preOk[reqBank];
      OP_REFRESH, OP_LOADMODE: begin
        illegal  = |bankOpen;
        timingOk = &rpDone;
      end
      default: illegal = 1'b1;
    endcase
    hostGo   = reqValid && !refPending && (illegal || (timingOk && quietOk));
    reqReady = hostGo;
  end

  // Command selection: refresh sequence first, then the host
  always_comb begin
    strobe   = '0;
    nextPins = PIN_NOP;
    nextBa   = '0;
    nextAddr = '0;
    if (refPending) begin
      if (|bankOpen) begin
        if ((&preOk) && quietOk) begin
          strobe.prech     = 1'b1;
          strobe.all       = 1'b1;
          nextPins         = PIN_PRECH;
          nextAddr[AP_BIT] = 1'b1;
        end
      end else if ((&rpDone) && quietOk) begin
        strobe.refresh = 1'b1;
        nextPins       = PIN_REFRESH;
      end
    end else if (hostGo && !illegal) begin
      strobe.bank    = reqBank;
      strobe.autoPre = apBit;
      nextBa         = reqBank;
      nextAddr       = reqAddr;
      case (reqOp)
        OP_ACT:   begin strobe.act   = 1'b1; nextPins = PIN_ACT;   end
        OP_READ:  begin strobe.colRd = 1'b1; nextPins = PIN_READ;  end
        OP_WRITE: begin strobe.colWr = 1'b1; nextPins = PIN_WRITE; end
        OP_PRECH: begin
          strobe.prech = 1'b1;
          strobe.all   = apBit;
          nextPins     = PIN_PRECH;
        end
        OP_REFRESH: begin
          strobe.refresh = 1'b1;
          nextPins       = PIN_REFRESH;
          nextBa         = '0;
          nextAddr       = '0;
        end
        OP_LOADMODE: begin strobe.loadMode = 1'b1; nextPins = PIN_LOADMODE; end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      refPending <= 1'b0;
      cmdPins    <= PIN_NOP;
      pinBa      <= '0;
      pinAddr    <= '0;
      pendAge    <= '0;
    end else begin
      if (refDue)                            refPending <= 1'b1;
      else if (refPending && strobe.refresh) refPending <= 1'b0;
      cmdPins <= nextPins;
      pinBa   <= nextBa;
      pinAddr <= nextAddr;
      if (!refPending)                       pendAge <= '0;
      else if (pendAge != AGE_W'(REF_BOUND + 1)) pendAge <= pendAge + 1'b1;
    end
  end

  AST_ONE_COMMAND: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.act, strobe.colRd, strobe.colWr, strobe.prech,
              strobe.refresh, strobe.loadMode})); // R1
  AST_NOP_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.act | strobe.colRd | strobe.colWr | strobe.prech |
      strobe.refresh | strobe.loadMode) |=> (cmdPins == PIN_NOP)); // R2
  AST_REF_ALL_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.refresh || strobe.loadMode) |-> (bankOpen == '0 && (&rpDone))); // R8
  AST_REFRESH_BOUNDED: assert property (@(posedge clk) disable iff (!rstN)
    pendAge <= AGE_W'(REF_BOUND)); // R9

endmodule

// File: rtl/sdram_cmd_seq.sv
module sdram_cmd_seq
  import sdram_seq_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int AP_BIT = 10,
  parameter int T_RCD  = 2,
  parameter int T_RAS  = 4,
  parameter int T_RC   = 6,
  parameter int T_RP   = 2,
  parameter int T_WR   = 2,
  parameter int T_RRD  = 2,
  parameter int T_RFC  = 7,
  parameter int T_MRD  = 2,
  parameter int T_REFI = 1560
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [2:0]        reqOp,
  input  logic [1:0]        reqBank,
  input  logic [ADDR_W-1:0] reqAddr,
  output logic              sdCsN,
  output logic              sdRasN,
  output logic              sdCasN,
  output logic              sdWeN,
  output logic [1:0]        sdBa,
  output logic [ADDR_W-1:0] sdAddr
);

  localparam int REF_BOUND = T_RFC + T_MRD + T_RAS + T_WR + T_RP + 4;

  seqStrobe_t       strobe;
  logic [BANKS-1:0] bankOpen, colOk, rasDone, preOk, rpDone, rcDone;
  logic             rrdOk, quietOk, refDue;
  logic [3:0]       cmdPins;

  seq_ctrl #(
    .ADDR_W(ADDR_W), .AP_BIT(AP_BIT), .REF_BOUND(REF_BOUND)
  ) u_ctrl (
    .clk(clk), .rstN(rstN),
    .reqValid(reqValid), .reqReady(reqReady), .reqOp(reqOp),
    .reqBank(reqBank), .reqAddr(reqAddr),
    .bankOpen(bankOpen), .colOk(colOk), .rasDone(rasDone), .preOk(preOk),
    .rpDone(rpDone), .rcDone(rcDone), .rrdOk(rrdOk), .quietOk(quietOk),
    .refDue(refDue), .strobe(strobe),
    .cmdPins(cmdPins), .pinBa(sdBa), .pinAddr(sdAddr)
  );

  seq_bank_timers #(
    .T_RCD(T_RCD), .T_RAS(T_RAS), .T_RC(T_RC), .T_RP(T_RP), .T_WR(T_WR),
    .T_RRD(T_RRD), .T_RFC(T_RFC), .T_MRD(T_MRD), .T_REFI(T_REFI)
  ) u_timers (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .bankOpen(bankOpen), .colOk(colOk), .rasDone(rasDone), .preOk(preOk),
    .rpDone(rpDone), .rcDone(rcDone), .rrdOk(rrdOk), .quietOk(quietOk),
    .refDue(refDue)
  );

  assign {sdCsN, sdRasN, sdCasN, sdWeN} = cmdPins;

endmodule

// File: tb/sdram_cmd_seq_tb.sv
module sdram_cmd_seq_tb;
  import sdram_seq_pkg::*;

  localparam int T_RCD = 2, T_RAS = 4, T_RC = 6, T_RP = 2, T_WR = 2;
  localparam int T_RRD = 2, T_RFC = 7, T_MRD = 2, T_REFI = 400;
  localparam int GAP_MAX = T_REFI + T_RFC + T_MRD + T_RAS + T_WR + T_RP + 6;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [2:0]  reqOp = '0;
  logic [1:0]  reqBank = '0;
  logic [11:0] reqAddr = '0;
  logic        sdCsN, sdRasN, sdCasN, sdWeN;
  logic [1:0]  sdBa;
  logic [11:0] sdAddr;

  int checks = 0, errors = 0, cyc = 0, refCount = 0;
  int lastAct[4], earliestAct[4], lastWr[4];
  bit open[4];
  int lastActAny = -1000, quietUntil = 0, lastRef = 0;

  always #5 clk = ~clk;

  sdram_cmd_seq #(.T_REFI(T_REFI)) u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqOp(reqOp), .reqBank(reqBank), .reqAddr(reqAddr),
    .sdCsN(sdCsN), .sdRasN(sdRasN), .sdCasN(sdCasN), .sdWeN(sdWeN),
    .sdBa(sdBa), .sdAddr(sdAddr)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  function automatic logic [3:0] pinsFor(input logic [2:0] op);
    case (op)
      OP_ACT:      return PIN_ACT;
      OP_READ:     return PIN_READ;
      OP_WRITE:    return PIN_WRITE;
      OP_PRECH:    return PIN_PRECH;
      OP_REFRESH:  return PIN_REFRESH;
      OP_LOADMODE: return PIN_LOADMODE;
      default:     return PIN_NOP;
    endcase
  endfunction

  function automatic bit anyOpen();
    return open[0] | open[1] | open[2] | open[3];
  endfunction

  function automatic bit isLegal(input logic [2:0] op, input int b);
    case (op)
      OP_ACT:                  return !open[b];
      OP_READ, OP_WRITE:       return open[b];
      OP_PRECH:                return 1'b1;
      OP_REFRESH, OP_LOADMODE: return !anyOpen();
      default:                 return 1'b0;
    endcase
  endfunction

  // Pin monitor: spacing rules judged from timestamps of observed commands
  task automatic observe();
    logic [3:0] p;
    int b;
    p = {sdCsN, sdRasN, sdCasN, sdWeN};
    b = int'(sdBa);
    if (p == PIN_NOP) return;
    check(cyc >= quietUntil, "R8 command inside refresh/mode quiet time", cyc, quietUntil);
    case (p)
      PIN_ACT: begin
        check(!open[b], "R4 open-row on open bank", 1, 0);
        check(cyc - lastAct[b] >= T_RC, "R7 same-bank open-row spacing", cyc - lastAct[b], T_RC);
        check(cyc >= earliestAct[b], "R7 open-row after close", cyc, earliestAct[b]);
        check(cyc - lastActAny >= T_RRD, "R7 cross-bank open-row spacing", cyc - lastActAny, T_RRD);
        open[b] = 1'b1; lastAct[b] = cyc; lastActAny = cyc;
      end
      PIN_READ, PIN_WRITE: begin
        check(open[b], "R4 column command on idle bank", 0, 1);
        check(cyc - lastAct[b] >= T_RCD, "R5 open-row to column", cyc - lastAct[b], T_RCD);
        if (sdAddr[10]) begin
          check(cyc - lastAct[b] >= T_RAS, "R5 auto-close before active time", cyc - lastAct[b], T_RAS);
          open[b] = 1'b0;
          earliestAct[b] = cyc + T_RP + ((p == PIN_WRITE) ? T_WR : 0);
        end else if (p == PIN_WRITE) begin
          lastWr[b] = cyc;
        end
      end
      PIN_PRECH: begin
        for (int k = 0; k < 4; k++) begin
          if ((sdAddr[10] || k == b) && open[k]) begin
            check(cyc - lastAct[k] >= T_RAS, "R6 close before active time", cyc - lastAct[k], T_RAS);
            check(cyc - lastWr[k] >= T_WR, "R6 close before write recovery", cyc - lastWr[k], T_WR);
            open[k] = 1'b0; earliestAct[k] = cyc + T_RP;
          end
        end
      end
      PIN_REFRESH, PIN_LOADMODE: begin
        check(!anyOpen(), "R4 refresh/mode with open bank", 1, 0);
        for (int k = 0; k < 4; k++)
          check(cyc >= earliestAct[k], "R8 refresh/mode before precharge time", cyc, earliestAct[k]);
        if (p == PIN_REFRESH) begin
          check(cyc - lastRef <= GAP_MAX, "R9 refresh gap", cyc - lastRef, GAP_MAX);
          lastRef = cyc; refCount++; quietUntil = cyc + T_RFC;
        end else begin
          quietUntil = cyc + T_MRD;
        end
      end
      default: check(1'b0, "R1 unknown pin pattern", int'(p), int'(PIN_NOP));
    endcase
  endtask

  always @(posedge clk) begin
    cyc++;
    #2;
    if (rstN) observe();
  end

  // Drive one request, wait for the handshake, check the pins one cycle later
  task automatic sendReq(input logic [2:0] op, input int b, input logic [11:0] addr,
                         input string tag, output int pinCyc);
    bit legal;
    logic [3:0] expPins;
    logic [1:0] expBa;
    logic [11:0] expAddr;
    reqValid = 1'b1; reqOp = op; reqBank = 2'(b); reqAddr = addr;
    #1;
    while (!reqReady) begin
      @(negedge clk); #1;
    end
    legal   = isLegal(op, b);
    expPins = legal ? pinsFor(op) : PIN_NOP;
    expBa   = (legal && op != OP_REFRESH) ? 2'(b) : 2'b00;
    expAddr = (legal && op != OP_REFRESH) ? addr : 12'h000;
    @(posedge clk);
    @(negedge clk);
    reqValid = 1'b0;
    pinCyc = cyc;
    check({sdCsN, sdRasN, sdCasN, sdWeN} == expPins,
          legal ? {tag, " R1 pins"} : {tag, " R4 dropped request"},
          int'({sdCsN, sdRasN, sdCasN, sdWeN}), int'(expPins));
    if (legal) begin
      check(sdBa == expBa, {tag, " R1 bank pins"}, int'(sdBa), int'(expBa));
      check(sdAddr == expAddr, {tag, " R1 address pins"}, int'(sdAddr), int'(expAddr));
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired actual=%0d expected=0", cyc);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int t0, t1, t2, t3, t4, t5, t6, t7, t8, t9, t10, tx;
    int b, r;
    logic [2:0] op;
    for (int k = 0; k < 4; k++) begin
      lastAct[k] = -1000; lastWr[k] = -1000; earliestAct[k] = 0; open[k] = 1'b0;
    end
    void'($urandom(32'd2718));
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    lastRef = cyc;
    @(negedge clk);
    check({sdCsN, sdRasN, sdCasN, sdWeN} == PIN_NOP, "R2 pins after reset",
          int'({sdCsN, sdRasN, sdCasN, sdWeN}), int'(PIN_NOP));
    check(reqReady == 1'b0, "R2 ready low without request", int'(reqReady), 0);

    // Directed: dropped request and exact earliest-issue spacing
    sendReq(OP_READ, 2, 12'h005, "R4 read idle bank", tx);
    sendReq(OP_ACT, 0, 12'h123, "dir", t0);
    sendReq(OP_ACT, 1, 12'h045, "dir", t1);
    check(t1 == max2(t0 + 1, t0 + T_RRD), "R10 R7 cross-bank open-row", t1 - t0, T_RRD);
    sendReq(OP_WRITE, 0, 12'h010, "dir", t2);
    check(t2 == max2(t1 + 1, t0 + T_RCD), "R10 R5 write after open", t2, max2(t1 + 1, t0 + T_RCD));
    sendReq(OP_PRECH, 0, 12'h000, "dir", t3);
    check(t3 == max2(max2(t2 + 1, t0 + T_RAS), t2 + T_WR), "R10 R6 close spacing",
          t3, max2(max2(t2 + 1, t0 + T_RAS), t2 + T_WR));
    sendReq(OP_ACT, 0, 12'h321, "dir", t4);
    check(t4 == max2(t3 + T_RP, t0 + T_RC), "R10 R7 reopen spacing", t4, max2(t3 + T_RP, t0 + T_RC));
    sendReq(OP_READ, 1, 12'h408, "dir", t5);
    check(t5 == max2(max2(t4 + 1, t1 + T_RAS), t1 + T_RCD), "R10 R5 R3 read with auto close",
          t5, max2(max2(t4 + 1, t1 + T_RAS), t1 + T_RCD));
    sendReq(OP_ACT, 1, 12'h046, "dir", t6);
    check(t6 == max2(max2(t5 + T_RP, t1 + T_RC), t4 + T_RRD), "R10 R3 R7 open after auto close",
          t6, max2(max2(t5 + T_RP, t1 + T_RC), t4 + T_RRD));
    sendReq(OP_PRECH, 3, 12'h400, "dir", t7);
    check(t7 == max2(max2(t6 + 1, t6 + T_RAS), t4 + T_RAS), "R10 R3 all-bank close",
          t7, max2(t6 + T_RAS, t4 + T_RAS));
    check(!anyOpen(), "R3 all banks closed", int'(anyOpen()), 0);
    sendReq(OP_REFRESH, 0, 12'h000, "dir", t8);
    check(t8 == t7 + T_RP, "R10 R8 refresh after close", t8, t7 + T_RP);
    sendReq(OP_LOADMODE, 0, 12'h032, "dir", t9);
    check(t9 == t8 + T_RFC, "R10 R8 mode after refresh", t9, t8 + T_RFC);
    sendReq(OP_ACT, 3, 12'h077, "dir", t10);
    check(t10 == t9 + T_MRD, "R10 R8 open after mode", t10, t9 + T_MRD);
    sendReq(OP_LOADMODE, 0, 12'h032, "R4 mode with open bank", tx);
    sendReq(3'd7, 2, 12'h000, "R4 undefined op", tx);
    sendReq(OP_WRITE, 3, 12'h400, "dir", tx);
    check(!open[3], "R3 write with auto close closes bank", int'(open[3]), 0);
    sendReq(OP_ACT, 3, 12'h078, "dir", t1);
    check(t1 - tx == T_WR + T_RP, "R10 R7 open after write auto close", t1 - tx, T_WR + T_RP);

    // Random traffic against the refresh demand
    for (int n = 0; n < 3000; n++) begin
      b = int'($urandom_range(0, 3));
      r = int'($urandom_range(0, 99));
      if (open[b]) begin
        if (r < 35)      op = OP_READ;
        else if (r < 65) op = OP_WRITE;
        else if (r < 90) op = OP_PRECH;
        else if (r < 94) op = OP_ACT;
        else if (r < 97) op = OP_REFRESH;
        else             op = 3'd6;
      end else begin
        if (r < 70)      op = OP_ACT;
        else if (r < 78) op = OP_PRECH;
        else if (r < 84) op = OP_REFRESH;
        else if (r < 88) op = OP_LOADMODE;
        else if (r < 94) op = OP_READ;
        else             op = 3'd7;
      end
      sendReq(op, b, 12'($urandom), "rnd", tx);
      if ($urandom_range(0, 9) == 0) repeat ($urandom_range(1, 6)) @(negedge clk);
    end
    repeat (GAP_MAX) @(negedge clk);
    check(refCount >= (cyc / T_REFI) - 1, "R9 refresh count", refCount, (cyc / T_REFI) - 1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule